// File: doc/BRIEF.md
# Dual-Bank Concurrent Read Router

This block steers the read path of a flash array that is split into two banks, so that one bank can be read while the other is erasing, programming or taking part in a command sequence. For every address it works out which bank is addressed. The controller reports a busy flag for each bank, and each bank also holds its own read mode. From these the router returns one of three things: an array word, the captured status byte, or an identifier word. The host does not write any command to move between the two banks. It changes the address, and the router returns status for a busy bank and array data for an idle one.

The router also gives the block number of the addressed location, for a bottom-boot or a top-boot address map. The map is chosen by a parameter when the block is elaborated. The output enable follows the chip-enable, output-enable and power-down inputs. In this model the array is a small synchronous memory that is loaded through a write port. The 20-bit address is folded down to the memory's index width.

Top module: `dual_bank_read_router`

## Requirements
- R1: `bank_hi` is 0 when the addressed location is in the lower (boot/parameter) bank. That bank is addr[19:17]==0 in the bottom-boot map and addr[19:17]==7 in the top-boot map. The output is registered, so it reflects the address presented at the previous clock edge.
- R2: Block numbers run from 0 to 35. Bottom-boot map: the lower bank gives blk_num = addr[19:14], and the upper bank gives blk_num = addr[19:15] + 4. Top-boot map: the upper bank gives blk_num = addr[19:15], and the lower bank gives blk_num = addr[19:14] - 28. The output is registered.
- R3: When a read addresses a bank whose busy input is high, the returned word is {8'h00, captured status}, whatever that bank's read mode is.
- R4: When a read addresses an idle bank in array mode, it returns the memory word at the folded index, one cycle after the address, even while the other bank is busy. The folded index XORs address bit i into index bit i mod MEM_AW.
- R5: Each bank keeps its own read mode. Writing `mode_code` sets the mode of the addressed bank only: 0 selects array, 1 selects status, 2 selects identifier. In identifier mode, addr[0]=0 returns MFR_ID and addr[0]=1 returns DEV_ID.
- R6: A mode write with code 3 leaves the addressed bank's mode unchanged.
- R7: The status byte is captured in the cycle where the read window opens, that is, where ce_n, oe_n and pwr_n first become all active. It is held for as long as the window stays open. A new status value shows only after ce_n or oe_n has been toggled.
- R8: When ce_n was high, oe_n was high or pwr_n was low at the previous edge, `dq_oe` is 0 and `dq_out` is 0.
- R9: While pwr_n is low, both banks return to array mode, mode writes are ignored and the captured status clears to 0.
- R10: A synchronous active-high `rst` clears `dq_oe`, `dq_out`, `bank_hi`, `blk_num` and both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| pwr_n | input | 1 | Power-down input, active low |
| addr | input | ADDR_W | Word address |
| busy_lo | input | 1 | Lower bank busy or in a command sequence |
| busy_hi | input | 1 | Upper bank busy or in a command sequence |
| status_in | input | STAT_W | Status byte from the controller |
| mode_we | input | 1 | Write read mode of the addressed bank |
| mode_code | input | 2 | Mode: 0 array, 1 status, 2 identifier, 3 ignored |
| mem_we | input | 1 | Array memory write enable |
| mem_waddr | input | MEM_AW | Array memory write index |
| mem_wdata | input | DATA_W | Array memory write data |
| dq_out | output | DATA_W | Read data, 0 while disabled |
| dq_oe | output | 1 | Data bus drive enable (0 = high impedance) |
| bank_hi | output | 1 | Addressed bank is the upper bank |
| blk_num | output | 6 | Addressed block number |

## Verification
The bench goes after the bank edges at 0x1FFFF/0x20000 and 0xDFFFF/0xE0000 in both address maps, and the boot block at the top of the space. A map with an off-by-one bank decode would give block numbers that shift by four or jump across the 28 boundary. It reads one bank while the other is busy. A router that chooses status from the wrong busy flag would return status where array data is expected. It checks that status stays frozen while the read window is open. A design that captures status every cycle would show the new value before the toggle. It also checks that a mode set on one bank, a code-3 write and a write made during power-down all leave the other bank or the mode unchanged. A shared mode register would return identifier codes from the wrong bank.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic [1:0] {
    RM_ARRAY  = 2'd0,
    RM_STATUS = 2'd1,
    RM_IDENT  = 2'd2,
    RM_RSVD   = 2'd3
  } rmode_e;

  typedef enum logic [1:0] {
    SRC_ARR  = 2'd0,
    SRC_STAT = 2'd1,
    SRC_ID   = 2'd2
  } src_e;

  localparam int BLK_W   = 6;
  localparam int NBLK    = 36;
  localparam int NBANK   = 2;
  localparam int LO_BLKS = 8;
endpackage

// File: rtl/dbr_bank_map.sv
module dbr_bank_map
  import dbr_pkg::*;
#(
  parameter bit TOP_BOOT = 1'b0
) (
  input  logic [5:0]       hi_bits,
  output logic             is_hi,
  output logic [BLK_W-1:0] blk
);
  logic [2:0] bank_f;
  logic [4:0] big_idx;

  assign bank_f  = hi_bits[5:3];
  assign big_idx = hi_bits[5:1];

  generate
    if (TOP_BOOT) begin : g_top
      localparam logic [BLK_W-1:0] LO_BASE = BLK_W'(NBLK - LO_BLKS);
      always_comb begin
        is_hi = (bank_f != 3'b111);
        blk   = is_hi ? {1'b0, big_idx} : hi_bits - LO_BASE;
      end
    end else begin : g_bottom
      always_comb begin
        is_hi = (bank_f != 3'b000);
        blk   = is_hi ? {1'b0, big_idx} + BLK_W'(LO_BLKS / 2) : hi_bits;
      end
    end
  endgenerate
endmodule

// File: rtl/dbr_mode_track.sv
module dbr_mode_track
  import dbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   pwr_n,
  input  logic   we,
  input  logic   bank_sel,
  input  rmode_e code,
  output rmode_e mode_lo,
  output rmode_e mode_hi
);
  rmode_e mode_r [NBANK];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst || !pwr_n)
        mode_r[b] <= RM_ARRAY;
      else if (we && (bank_sel == (b == 1)) && code != RM_RSVD)
        mode_r[b] <= code;
    end
  end

  assign mode_lo = mode_r[0];
  assign mode_hi = mode_r[1];
endmodule

// File: rtl/dbr_array_mem.sv
module dbr_array_mem #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    rdata <= store[raddr];
  end
endmodule

// File: rtl/dual_bank_read_router.sv
module dual_bank_read_router
  import dbr_pkg::*;
#(
  parameter int                ADDR_W   = 20,
  parameter int                DATA_W   = 16,
  parameter int                STAT_W   = 8,
  parameter int                MEM_AW   = 8,
  parameter bit                TOP_BOOT = 1'b0,
  parameter logic [DATA_W-1:0] MFR_ID   = 'h00C5,
  parameter logic [DATA_W-1:0] DEV_ID   = 'h00D2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              pwr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy_lo,
  input  logic              busy_hi,
  input  logic [STAT_W-1:0] status_in,
  input  logic              mode_we,
  input  logic [1:0]        mode_code,
  input  logic              mem_we,
  input  logic [MEM_AW-1:0] mem_waddr,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              bank_hi,
  output logic [BLK_W-1:0]  blk_num
);
  localparam int PAD = DATA_W - STAT_W;

  logic              active, start, act_q, oe_q;
  logic              map_hi, busy_sel, bank_q;
  logic [BLK_W-1:0]  map_blk, blk_q;
  rmode_e            mode_lo, mode_hi, mode_sel;
  src_e              src_n, src_q;
  logic [STAT_W-1:0] stat_q;
  logic [DATA_W-1:0] id_q, mem_q;
  logic [MEM_AW-1:0] raddr;

  dbr_bank_map #(.TOP_BOOT(TOP_BOOT)) u_map (
    .hi_bits (addr[ADDR_W-1 -: 6]),
    .is_hi   (map_hi),
    .blk     (map_blk)
  );

  dbr_mode_track u_modes (
    .clk      (clk),
    .rst      (rst),
    .pwr_n    (pwr_n),
    .we       (mode_we),
    .bank_sel (map_hi),
    .code     (rmode_e'(mode_code)),
    .mode_lo  (mode_lo),
    .mode_hi  (mode_hi)
  );

  always_comb begin
    raddr = '0;
    for (int i = 0; i < ADDR_W; i++)
      raddr[i % MEM_AW] = raddr[i % MEM_AW] ^ addr[i];
  end

  dbr_array_mem #(.AW(MEM_AW), .DW(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (raddr),
    .rdata (mem_q)
  );

  assign active = !ce_n && !oe_n && pwr_n;
  assign start  = active && !act_q;

  always_comb begin
    mode_sel = map_hi ? mode_hi : mode_lo;
    busy_sel = map_hi ? busy_hi : busy_lo;
    if (busy_sel || mode_sel == RM_STATUS) src_n = SRC_STAT;
    else if (mode_sel == RM_IDENT)         src_n = SRC_ID;
    else                                   src_n = SRC_ARR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q  <= '0;
      bank_q <= 1'b0;
    end else begin
      blk_q  <= map_blk;
      bank_q <= map_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr_n) begin
      act_q  <= 1'b0;
      oe_q   <= 1'b0;
      src_q  <= SRC_ARR;
      stat_q <= '0;
      id_q   <= '0;
    end else begin
      act_q <= active;
      oe_q  <= active;
      src_q <= src_n;
      id_q  <= addr[0] ? DEV_ID : MFR_ID;
      if (start) stat_q <= status_in;
    end
  end

  always_comb begin
    if (!oe_q) dq_out = '0;
    else begin
      case (src_q)
        SRC_STAT: dq_out = {{PAD{1'b0}}, stat_q};
        SRC_ID:   dq_out = id_q;
        default:  dq_out = mem_q;
      endcase
    end
  end

  assign dq_oe   = oe_q;
  assign bank_hi = bank_q;
  assign blk_num = blk_q;
endmodule

// File: rtl/dbr_checker.sv
module dbr_checker
  import dbr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              oe_n,
  input logic              pwr_n,
  input logic              busy_lo,
  input logic              busy_hi,
  input logic              map_hi,
  input logic              start,
  input logic [STAT_W-1:0] stat_q,
  input rmode_e            mode_lo,
  input rmode_e            mode_hi,
  input logic [DATA_W-1:0] dq_out,
  input logic              dq_oe,
  input logic [BLK_W-1:0]  blk_num
);
  // R8
  oe_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_n || oe_n || !pwr_n) |=> !dq_oe);

  // R8
  quiet_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !dq_oe |-> dq_out == '0);

  // R2
  blk_range_chk: assert property (@(posedge clk) disable iff (rst)
    blk_num < BLK_W'(NBLK));

  // R9
  pwr_mode_chk: assert property (@(posedge clk) disable iff (rst)
    !pwr_n |=> (mode_lo == RM_ARRAY && mode_hi == RM_ARRAY));

  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_q != $past(stat_q)) |-> ($past(start) || !$past(pwr_n)));

  // R3
  busy_stat_chk: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !oe_n && pwr_n && (map_hi ? busy_hi : busy_lo))
      |=> (dq_oe && dq_out[DATA_W-1:STAT_W] == '0));
endmodule

bind dual_bank_read_router dbr_checker #(.DATA_W(DATA_W), .STAT_W(STAT_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .ce_n    (ce_n),
  .oe_n    (oe_n),
  .pwr_n   (pwr_n),
  .busy_lo (busy_lo),
  .busy_hi (busy_hi),
  .map_hi  (map_hi),
  .start   (start),
  .stat_q  (stat_q),
  .mode_lo (mode_lo),
  .mode_hi (mode_hi),
  .dq_out  (dq_out),
  .dq_oe   (dq_oe),
  .blk_num (blk_num)
);

// File: tb/test_dual_bank_read_router.sv
module test_dual_bank_read_router;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] MFR = 16'h00C5;
  localparam logic [15:0] DEV = 16'h00D2;

  logic        clk = 0, rst = 1, ce_n = 1, oe_n = 1, pwr_n = 1;
  logic [19:0] addr = '0;
  logic        busy_lo = 0, busy_hi = 0, mode_we = 0, mem_we = 0;
  logic [7:0]  status_in = '0;
  logic [1:0]  mode_code = '0;
  logic [7:0]  mem_waddr = '0;
  logic [15:0] mem_wdata = '0;
  logic [15:0] dq_out, t_dq;
  logic        dq_oe, bank_hi, t_oe, t_bank;
  logic [5:0]  blk_num, t_blk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  bit         m_act;
  logic [7:0] m_stat;
  int         m_mode [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_bank_read_router i_dual_bank_read_router (
    .clk, .rst, .ce_n, .oe_n, .pwr_n, .addr, .busy_lo, .busy_hi, .status_in,
    .mode_we, .mode_code, .mem_we, .mem_waddr, .mem_wdata,
    .dq_out, .dq_oe, .bank_hi, .blk_num);

  dual_bank_read_router #(.TOP_BOOT(1'b1)) i_dual_bank_read_router_top (
    .clk, .rst, .ce_n, .oe_n, .pwr_n, .addr, .busy_lo, .busy_hi, .status_in,
    .mode_we, .mode_code, .mem_we, .mem_waddr, .mem_wdata,
    .dq_out(t_dq), .dq_oe(t_oe), .bank_hi(t_bank), .blk_num(t_blk));

  function automatic logic [15:0] memval(int j);
    return 16'((j * 16'h9E37) ^ 16'h5A5A);
  endfunction

  function automatic logic [7:0] fold(logic [19:0] a);
    logic [7:0] r = '0;
    for (int i = 0; i < 20; i++) r[i % 8] ^= a[i];
    return r;
  endfunction

  function automatic logic [5:0] blk_bot(logic [19:0] a);
    if (a[19:17] == 3'd0) return a[19:14];
    return 6'(a[19:15]) + 6'd4;
  endfunction

  function automatic logic [5:0] blk_top(logic [19:0] a);
    if (a[19:17] == 3'd7) return a[19:14] - 6'd28;
    return 6'(a[19:15]);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (addr %h)", req, act, exp, addr);
    end
  endtask

  task automatic step(string req);
    logic [15:0] e_dq;
    logic        e_oe, hi, act, st;
    logic [5:0]  e_bb, e_bt;
    logic        e_hb, e_ht;
    int          md;
    hi = (addr[19:17] != 3'd0);
    if (rst) begin
      e_oe = 0; e_dq = 0; e_bb = 0; e_bt = 0; e_hb = 0; e_ht = 0;
      m_act = 0; m_stat = 0; m_mode[0] = 0; m_mode[1] = 0;
    end else begin
      e_bb = blk_bot(addr); e_bt = blk_top(addr);
      e_hb = hi; e_ht = (addr[19:17] != 3'd7);
      if (!pwr_n) begin
        e_oe = 0; e_dq = 0; m_act = 0; m_stat = 0;
        m_mode[0] = 0; m_mode[1] = 0;
      end else begin
        act = !ce_n && !oe_n;
        st  = act && !m_act;
        if (st) m_stat = status_in;
        md = m_mode[hi];
        e_oe = act;
        if (!act) e_dq = 0;
        else if ((hi ? busy_hi : busy_lo) || md == 1) e_dq = {8'h00, m_stat};
        else if (md == 2) e_dq = addr[0] ? DEV : MFR;
        else e_dq = memval(fold(addr));
        m_act = act;
        if (mode_we && mode_code != 2'd3) m_mode[hi] = mode_code;
      end
    end
    @(negedge clk);
    chk({req, " dq_oe"}, 16'(dq_oe), 16'(e_oe));
    chk({req, " dq_out"}, dq_out, e_dq);
    chk("R2 bottom", 16'(blk_num), 16'(e_bb));
    chk("R1 bottom", 16'(bank_hi), 16'(e_hb));
    chk("R2 top", 16'(t_blk), 16'(e_bt));
    chk("R1 top", 16'(t_bank), 16'(e_ht));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [19:0] edges [6] = '{20'h00000, 20'h1FFFF, 20'h20000,
                                20'hDFFFF, 20'hE0000, 20'hFC000};
    void'($urandom(32'd2718));
    @(negedge clk);
    rst = 1;
    step("R10");
    step("R10");
    rst = 0;

    // load the array model
    mem_we = 1;
    for (int j = 0; j < 256; j++) begin
      mem_waddr = 8'(j); mem_wdata = memval(j);
      step("R4 load");
    end
    mem_we = 0;

    // R4: idle lower bank read while upper is busy
    busy_hi = 1; ce_n = 0; oe_n = 0; addr = 20'h00010;
    step("R4");
    addr = 20'h0A5C3;
    step("R4");
    // R3: busy lower bank returns status
    busy_hi = 0; busy_lo = 1; oe_n = 1; step("R8");
    oe_n = 0; status_in = 8'h80; addr = 20'h00020;
    step("R3");
    // R7: status frozen while window open
    status_in = 8'h81; step("R7");
    addr = 20'h00021; step("R7");
    oe_n = 1; step("R8");
    oe_n = 0; step("R7");
    ce_n = 1; step("R8");
    ce_n = 0; busy_lo = 0;

    // R5: per-bank modes
    addr = 20'h00000; mode_we = 1; mode_code = 2'd2; step("R5");
    mode_we = 0; step("R5");
    addr = 20'h00001; step("R5");
    addr = 20'h20005; step("R5");
    addr = 20'h20000; mode_we = 1; mode_code = 2'd1; step("R5");
    mode_we = 0; step("R5");
    addr = 20'h00001; step("R5");
    // R6: code 3 ignored
    addr = 20'h00000; mode_we = 1; mode_code = 2'd3; step("R6");
    mode_we = 0; step("R6");
    // R9: power-down resets modes, ignores writes
    pwr_n = 0; addr = 20'h20000; mode_we = 1; mode_code = 2'd2; step("R9");
    mode_we = 0; pwr_n = 1; addr = 20'h00004; step("R9");
    addr = 20'h20004; step("R9");
    addr = 20'h00000; step("R9");

    // R1 R2: bank and block boundaries in both maps
    foreach (edges[k]) begin
      addr = edges[k]; step("R2");
    end

    // random mix
    for (int n = 0; n < 600; n++) begin
      addr      = 20'($urandom);
      ce_n      = ($urandom % 4 == 0);
      oe_n      = ($urandom % 4 == 0);
      pwr_n     = ($urandom % 20 != 0);
      busy_lo   = $urandom % 2;
      busy_hi   = $urandom % 2;
      status_in = 8'($urandom);
      mode_we   = ($urandom % 6 == 0);
      mode_code = 2'($urandom);
      step("R4 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule